// File: doc/BRIEF.md
# NOR Flash Read Path and Status Polling Unit

This block sits on the read side of a parallel NOR flash device that uses the classic unlock-sequence command set. On every read strobe it chooses one of four sources according to the command mode the write decoder currently holds: array data from the storage, the polling status byte, an identification word, or a byte of the query table. The storage array, the contents of the query table and the decoding of write commands all live outside. This block reports the table index it wants and takes the byte back combinationally.

The status byte is what host software polls while a program or erase runs. A small operation-phase state machine follows the events that the write side reports. The phases are Idle, Program, Window (the short acceptance window in which more sectors may be queued for erase), Run (erase in progress) and Suspended. The transitions are: Idle to Program on a program event; Idle or Window to Window on an erase-start event; Window to Run on an erase-run event; Window or Run to Suspended on a suspend event; Suspended to Run on a resume event; and Program or Run to Idle on a done event. Each event also moves the polarity bit and the erase-active bit. Reads flip the toggle bits, and the pattern they follow depends on the mode. The status update caused by a read lands on the same clock edge that samples the strobe. The returned data is registered and appears one clock later.

Top module: `flash_rd_path`

## Requirements
- R1: With cmd_mode 0 (array), or the unused codes 6 and 7, and no suspended-erase hit, a read returns arr_data and leaves status unchanged.
- R2: The decode offset is rd_addr[7:0] shifted right by 0, 1 or 2 for a word of 1, 2 or 4 bytes; address bits above 7 have no effect on it; qry_idx carries this offset.
- R3: With cmd_mode 1 (identification), offset 0 returns the manufacturer ID, offset 1 the device ID, and offset 2 returns zero. Offsets 0x0E and 0x0F return the first and second extended IDs unless that ID's low byte is 0xFF. Those two cases and every other offset return arr_data.
- R4: With cmd_mode 2 (query), an offset below QRY_LEN returns tbl_byte zero-extended; a larger offset returns zero.
- R5: With cmd_mode 3 (program), a read inverts status bit 6 only and returns the updated status.
- R6: With cmd_mode 4 (sector erase) or 5 (chip erase), a read inverts status bits 6 and 2 and returns the updated status.
- R7: In array mode with erase_susp high, a read with sect_erasing high inverts bit 2 only and returns the status; with sect_erasing low it returns arr_data.
- R8: The event codes act on status as follows. Code 1 (program) sets bit 7 to the inverse of evt_d7. Code 2 (erase start) clears bits 7 and 3. Code 3 (erase run) sets bit 3. Code 4 (suspend) clears bit 3. Code 5 (resume) clears bit 7 and sets bit 3. Code 6 (done) inverts bit 7 and clears bit 3.
- R9: op_phase is encoded Idle 0, Program 1, Window 2, Run 3, Suspended 4. It follows the transitions named above, and an event arriving outside its allowed phases changes neither op_phase nor status.
- R10: Reset clears status, rd_data and rd_valid and puts op_phase in Idle; status bits 5, 4, 1 and 0 stay zero.
- R11: rd_valid and rd_data follow the read strobe by one clock; status changes only on a clock with a read strobe or an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one clock per read |
| rd_addr | input | AW | Byte address of the read |
| cmd_mode | input | 3 | Current command mode code |
| erase_susp | input | 1 | An erase is suspended |
| sect_erasing | input | 1 | The addressed sector is marked as erasing |
| arr_data | input | DW | Array data at rd_addr |
| tbl_byte | input | 8 | Query table byte at qry_idx |
| evt | input | 3 | Operation event code, 0 for none |
| evt_d7 | input | 1 | Bit 7 of the programmed data |
| qry_idx | output | 8 | Word offset for the query table |
| rd_data | output | DW | Registered read result |
| rd_valid | output | 1 | rd_data holds a new result |
| status | output | 8 | Current status byte |
| op_phase | output | 3 | Operation phase |

## Verification
A wrong phase state shows at the ports at the next event. The erase-active bit takes the wrong value, or a later event is accepted or dropped in the wrong way, and op_phase exposes the state right away. A wrong toggle pattern shows on the very next status read as a bit 6 or bit 2 that failed to flip, or flipped when it should not have. Offset and source selection errors appear in rd_data one clock after the strobe, so sweeping every address in each mode finds them directly.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

    typedef enum logic [2:0] {
        CM_ARRAY      = 3'd0,
        CM_IDENT      = 3'd1,
        CM_QUERY      = 3'd2,
        CM_PROGRAM    = 3'd3,
        CM_SECT_ERASE = 3'd4,
        CM_CHIP_ERASE = 3'd5
    } cmd_mode_e;

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_PROGRAM  = 3'd1,
        EV_ER_START = 3'd2,
        EV_ER_RUN   = 3'd3,
        EV_SUSPEND  = 3'd4,
        EV_RESUME   = 3'd5,
        EV_DONE     = 3'd6
    } op_evt_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_PROG   = 3'd1,
        PH_WINDOW = 3'd2,
        PH_RUN    = 3'd3,
        PH_SUSP   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        RK_ARRAY  = 2'd0,
        RK_STATUS = 2'd1,
        RK_IDENT  = 2'd2,
        RK_QUERY  = 2'd3
    } read_kind_e;

    localparam int SB_POLL   = 7;
    localparam int SB_TOGGLE = 6;
    localparam int SB_ERACT  = 3;
    localparam int SB_ALT    = 2;

endpackage

// File: rtl/fpr_offset.sv
`timescale 1ns/1ps
module fpr_offset #(
    parameter int AW    = 12,
    parameter int BYTES = 2
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    word_off
);
    localparam int SHIFT = (BYTES == 4) ? 2 : ((BYTES == 2) ? 1 : 0);

    logic [7:0] low_byte;
    assign low_byte = addr[7:0];

    generate
        if (SHIFT == 0) begin : g_byte
            assign word_off = low_byte;
        end else begin : g_wide
            assign word_off = {{SHIFT{1'b0}}, low_byte[7:SHIFT]};
        end
    endgenerate
endmodule

// File: rtl/fpr_lookup.sv
`timescale 1ns/1ps
module fpr_lookup #(
    parameter int          DW      = 16,
    parameter int          QRY_LEN = 77,
    parameter logic [15:0] MFR_ID  = 16'h0001,
    parameter logic [15:0] DEV_ID  = 16'h227E,
    parameter logic [15:0] EXT_ID0 = 16'h2210,
    parameter logic [15:0] EXT_ID1 = 16'h00FF
) (
    input  logic [7:0]    word_off,
    input  logic [DW-1:0] arr_data,
    input  logic [7:0]    tbl_byte,
    output logic [DW-1:0] id_word,
    output logic [DW-1:0] qry_word
);
    localparam bit EXT0_VALID = (EXT_ID0[7:0] != 8'hFF);
    localparam bit EXT1_VALID = (EXT_ID1[7:0] != 8'hFF);

    always_comb begin
        case (word_off)
            8'h00:   id_word = DW'(MFR_ID);
            8'h01:   id_word = DW'(DEV_ID);
            8'h02:   id_word = '0;
            8'h0E:   id_word = EXT0_VALID ? DW'(EXT_ID0) : arr_data;
            8'h0F:   id_word = EXT1_VALID ? DW'(EXT_ID1) : arr_data;
            default: id_word = arr_data;
        endcase
    end

    always_comb begin
        if (int'(word_off) < QRY_LEN) begin
            qry_word = DW'(tbl_byte);
        end else begin
            qry_word = '0;
        end
    end
endmodule

// File: rtl/fpr_status.sv
`timescale 1ns/1ps
module fpr_status
    import fpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] evt,
    input  logic       evt_d7,
    input  logic       flip_tgl,
    input  logic       flip_alt,
    output logic [7:0] status,
    output logic [7:0] status_nxt,
    output phase_e     phase
);
    phase_e     phase_nxt;
    logic       accept;
    logic [7:0] st_ev;
    op_evt_e    ev;

    assign ev = op_evt_e'(evt);

    // Phase state machine: legality and next phase
    always_comb begin
        accept    = 1'b0;
        phase_nxt = phase;
        unique case (ev)
            EV_PROGRAM: begin
                if (phase == PH_IDLE) begin
                    accept = 1'b1; phase_nxt = PH_PROG;
                end
            end
            EV_ER_START: begin
                if (phase == PH_IDLE || phase == PH_WINDOW) begin
                    accept = 1'b1; phase_nxt = PH_WINDOW;
                end
            end
            EV_ER_RUN: begin
                if (phase == PH_WINDOW) begin
                    accept = 1'b1; phase_nxt = PH_RUN;
                end
            end
            EV_SUSPEND: begin
                if (phase == PH_WINDOW || phase == PH_RUN) begin
                    accept = 1'b1; phase_nxt = PH_SUSP;
                end
            end
            EV_RESUME: begin
                if (phase == PH_SUSP) begin
                    accept = 1'b1; phase_nxt = PH_RUN;
                end
            end
            EV_DONE: begin
                if (phase == PH_PROG || phase == PH_RUN) begin
                    accept = 1'b1; phase_nxt = PH_IDLE;
                end
            end
            default: begin
                accept    = 1'b0;
                phase_nxt = phase;
            end
        endcase
    end

    // Status effect of an accepted event, then read toggles
    always_comb begin
        st_ev = status;
        if (accept) begin
            unique case (ev)
                EV_PROGRAM:  st_ev[SB_POLL] = ~evt_d7;
                EV_ER_START: begin
                    st_ev[SB_POLL]  = 1'b0;
                    st_ev[SB_ERACT] = 1'b0;
                end
                EV_ER_RUN:   st_ev[SB_ERACT] = 1'b1;
                EV_SUSPEND:  st_ev[SB_ERACT] = 1'b0;
                EV_RESUME: begin
                    st_ev[SB_POLL]  = 1'b0;
                    st_ev[SB_ERACT] = 1'b1;
                end
                EV_DONE: begin
                    st_ev[SB_POLL]  = ~status[SB_POLL];
                    st_ev[SB_ERACT] = 1'b0;
                end
                default: st_ev = status;
            endcase
        end
        status_nxt = st_ev;
        status_nxt[SB_TOGGLE] = st_ev[SB_TOGGLE] ^ flip_tgl;
        status_nxt[SB_ALT]    = st_ev[SB_ALT] ^ flip_alt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            status <= 8'h00;
        end else begin
            phase  <= phase_nxt;
            status <= status_nxt;
        end
    end

    // R8
    run_eract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |-> status[SB_ERACT]);

    // R8
    idle_eract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RUN) |-> !status[SB_ERACT]);

    // R9
    reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RESUME && phase != PH_SUSP) |=> $stable(phase));

    // R10
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status & 8'h33) == 0);
endmodule

// File: rtl/flash_rd_path.sv
`timescale 1ns/1ps
module flash_rd_path
    import fpr_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          BYTES   = 2,
    parameter int          QRY_LEN = 77,
    parameter logic [15:0] MFR_ID  = 16'h0001,
    parameter logic [15:0] DEV_ID  = 16'h227E,
    parameter logic [15:0] EXT_ID0 = 16'h2210,
    parameter logic [15:0] EXT_ID1 = 16'h00FF,
    localparam int         DW      = 8 * BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [2:0]    cmd_mode,
    input  logic          erase_susp,
    input  logic          sect_erasing,
    input  logic [DW-1:0] arr_data,
    input  logic [7:0]    tbl_byte,
    input  logic [2:0]    evt,
    input  logic          evt_d7,
    output logic [7:0]    qry_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [7:0]    status,
    output logic [2:0]    op_phase
);
    logic [7:0]    word_off;
    logic [DW-1:0] id_word;
    logic [DW-1:0] qry_word;
    logic [7:0]    status_nxt;
    logic          want_tgl;
    logic          want_alt;
    read_kind_e    kind;
    phase_e        phase;
    cmd_mode_e     mode;
    logic [DW-1:0] sel_word;

    assign mode = cmd_mode_e'(cmd_mode);

    fpr_offset #(.AW(AW), .BYTES(BYTES)) u_off (
        .addr     (rd_addr),
        .word_off (word_off)
    );

    fpr_lookup #(
        .DW(DW), .QRY_LEN(QRY_LEN), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
        .EXT_ID0(EXT_ID0), .EXT_ID1(EXT_ID1)
    ) u_lut (
        .word_off (word_off),
        .arr_data (arr_data),
        .tbl_byte (tbl_byte),
        .id_word  (id_word),
        .qry_word (qry_word)
    );

    // Read source classification by mode
    always_comb begin
        kind     = RK_ARRAY;
        want_tgl = 1'b0;
        want_alt = 1'b0;
        unique case (mode)
            CM_IDENT:  kind = RK_IDENT;
            CM_QUERY:  kind = RK_QUERY;
            CM_PROGRAM: begin
                kind     = RK_STATUS;
                want_tgl = 1'b1;
            end
            CM_SECT_ERASE, CM_CHIP_ERASE: begin
                kind     = RK_STATUS;
                want_tgl = 1'b1;
                want_alt = 1'b1;
            end
            default: begin
                if (erase_susp && sect_erasing) begin
                    kind     = RK_STATUS;
                    want_alt = 1'b1;
                end
            end
        endcase
    end

    fpr_status u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .evt_d7     (evt_d7),
        .flip_tgl   (rd_en && want_tgl),
        .flip_alt   (rd_en && want_alt),
        .status     (status),
        .status_nxt (status_nxt),
        .phase      (phase)
    );

    always_comb begin
        unique case (kind)
            RK_STATUS: sel_word = DW'(status_nxt);
            RK_IDENT:  sel_word = id_word;
            RK_QUERY:  sel_word = qry_word;
            default:   sel_word = arr_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel_word;
            end
        end
    end

    assign qry_idx  = word_off;
    assign op_phase = phase;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R11
    quiet_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && evt == 3'd0) |=> $stable(status));

    // R5
    prog_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cmd_mode == 3'd3 && evt == 3'd0) |=>
        (status[6] != $past(status[6])) && (status[2] == $past(status[2])));

    // R4
    qry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cmd_mode == 3'd2 && int'(qry_idx) >= QRY_LEN) |=> (rd_data == '0));
endmodule

// File: tb/tb_flash_rd_path.sv
`timescale 1ns/1ps
module tb_flash_rd_path;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [2:0]    cmd_mode = 3'd0;
    logic          erase_susp = 1'b0;
    logic          sect_erasing = 1'b0;
    logic [DW-1:0] arr_data;
    logic [7:0]    tbl_byte;
    logic [2:0]    evt = 3'd0;
    logic          evt_d7 = 1'b0;
    logic [7:0]    qry_idx;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [7:0]    status;
    logic [2:0]    op_phase;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_st = 8'h00;
    int         m_ph = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign arr_data = {4'hA, rd_addr};
    assign tbl_byte = qry_idx ^ 8'hC3;

    flash_rd_path dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .cmd_mode(cmd_mode), .erase_susp(erase_susp), .sect_erasing(sect_erasing),
        .arr_data(arr_data), .tbl_byte(tbl_byte), .evt(evt), .evt_d7(evt_d7),
        .qry_idx(qry_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status), .op_phase(op_phase)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // one read; model computed from the requirements
    task automatic rd(input string req, input int a, input int m, input bit su, input bit se);
        logic [15:0] av;
        logic [7:0]  off;
        logic [15:0] exp;
        av  = {4'hA, 12'(a)};
        off = 8'(a & 255) >> 1;
        case (m)
            1: begin
                if (off == 0) exp = 16'h0001;
                else if (off == 1) exp = 16'h227E;
                else if (off == 2) exp = 16'h0000;
                else if (off == 8'h0E) exp = 16'h2210;
                else exp = av;
            end
            2: exp = (off < 77) ? {8'h00, off ^ 8'hC3} : 16'h0000;
            3: begin m_st ^= 8'h40; exp = {8'h00, m_st}; end
            4, 5: begin m_st ^= 8'h44; exp = {8'h00, m_st}; end
            default: begin
                if (su && se) begin m_st ^= 8'h04; exp = {8'h00, m_st}; end
                else exp = av;
            end
        endcase
        @(negedge clk);
        rd_addr = AW'(a); cmd_mode = 3'(m); erase_susp = su; sect_erasing = se; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {16'h0, rd_data}, {16'h0, exp});
        chk("R11 valid", {31'h0, rd_valid}, 32'd1);
        chk(req, {24'h0, status}, {24'h0, m_st});
    endtask

    task automatic ev(input string req, input int code, input bit d7);
        bit ok;
        int nph;
        ok = 1'b0; nph = m_ph;
        case (code)
            1: if (m_ph == 0) begin ok = 1; nph = 1; m_st[7] = ~d7; end
            2: if (m_ph == 0 || m_ph == 2) begin ok = 1; nph = 2; m_st[7] = 0; m_st[3] = 0; end
            3: if (m_ph == 2) begin ok = 1; nph = 3; m_st[3] = 1; end
            4: if (m_ph == 2 || m_ph == 3) begin ok = 1; nph = 4; m_st[3] = 0; end
            5: if (m_ph == 4) begin ok = 1; nph = 3; m_st[7] = 0; m_st[3] = 1; end
            6: if (m_ph == 1 || m_ph == 3) begin ok = 1; nph = 0; m_st[7] = ~m_st[7]; m_st[3] = 0; end
            default: ok = 0;
        endcase
        m_ph = nph;
        @(negedge clk);
        evt = 3'(code); evt_d7 = d7;
        @(negedge clk);
        evt = 3'd0;
        chk(req, {24'h0, status}, {24'h0, m_st});
        chk(req, {29'h0, op_phase}, 32'(m_ph));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 status", {24'h0, status}, 32'h0);
        chk("R10 valid", {31'h0, rd_valid}, 32'h0);
        chk("R10 data", {16'h0, rd_data}, 32'h0);
        chk("R10 phase", {29'h0, op_phase}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle valid", {31'h0, rd_valid}, 32'h0);

        // R1 array sweep, plus unused codes
        for (int a = 0; a < 4096; a++) rd("R1 array", a, 0, 1'b0, 1'b0);
        for (int a = 0; a < 256; a += 7) rd("R1 code6", a, 6, 1'b0, 1'b0);
        for (int a = 0; a < 256; a += 5) rd("R1 code7", a, 7, 1'b0, 1'b0);
        // R2 R3 identification sweep over all addresses (upper bits ignored)
        for (int a = 0; a < 4096; a++) rd("R3 R2 ident", a, 1, 1'b0, 1'b0);
        // R2 R4 query sweep
        for (int a = 0; a < 4096; a++) rd("R4 R2 query", a, 2, 1'b0, 1'b0);
        rd_addr = 12'h3A5;
        #1 chk("R2 qry_idx", {24'h0, qry_idx}, 32'h52);

        // R5 R8 program with data bit 7 set and clear
        ev("R8 program", 1, 1'b1);
        for (int i = 0; i < 5; i++) rd("R5 program poll", i * 2, 3, 1'b0, 1'b0);
        ev("R8 done", 6, 1'b0);
        ev("R8 program d7=0", 1, 1'b0);
        for (int i = 0; i < 3; i++) rd("R5 program poll", i, 3, 1'b0, 1'b0);
        ev("R8 done", 6, 1'b0);

        // R9 illegal events ignored
        ev("R9 done in idle", 6, 1'b0);
        ev("R9 run in idle", 3, 1'b0);
        ev("R9 resume in idle", 5, 1'b0);
        ev("R9 suspend in idle", 4, 1'b0);

        // R6 R7 R8 sector erase with suspend
        ev("R8 erase start", 2, 1'b0);
        for (int i = 0; i < 3; i++) rd("R6 window poll", i, 4, 1'b0, 1'b0);
        ev("R8 erase start again", 2, 1'b0);
        ev("R9 program in window", 1, 1'b1);
        ev("R8 erase run", 3, 1'b0);
        for (int i = 0; i < 4; i++) rd("R6 sector poll", i, 4, 1'b0, 1'b0);
        ev("R8 suspend", 4, 1'b0);
        for (int i = 0; i < 3; i++) rd("R7 erasing sector", 16 + i, 0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) rd("R7 other sector", 40 + i, 0, 1'b1, 1'b0);
        rd("R7 flag without suspend", 9, 0, 1'b0, 1'b1);
        ev("R9 done in suspend", 6, 1'b0);
        ev("R8 resume", 5, 1'b0);
        ev("R9 run in run", 3, 1'b0);
        ev("R8 done", 6, 1'b0);

        // R6 chip erase
        ev("R8 erase start", 2, 1'b0);
        ev("R8 erase run", 3, 1'b0);
        for (int i = 0; i < 5; i++) rd("R6 chip poll", i * 3, 5, 1'b0, 1'b0);
        ev("R8 suspend from run", 4, 1'b0);
        ev("R8 resume", 5, 1'b0);
        ev("R8 done", 6, 1'b0);

        // R11 no strobe, no change
        repeat (6) @(negedge clk);
        chk("R11 stable status", {24'h0, status}, {24'h0, m_st});
        chk("R11 valid low", {31'h0, rd_valid}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule